// File: doc/BRIEF.md
# Single-Cycle Load/Store Processor Core

This block is a 32-bit processor core that finishes every instruction in the same clock cycle that fetches it. It runs eight instructions: word load, word store, branch-if-equal, and the register-to-register operations add, subtract, and, or and signed set-less-than. The core holds a program counter, a register file with two read ports and one write port, an ALU, a sign extender, a branch-target adder and the selection multiplexers. The instruction store and the data store are separate word arrays, so a fetch and a data access can happen in the same cycle.

Control has two levels. A main decoder sorts the opcode into one of five instruction classes: register-register, load, store, branch, or none. From that class it sets the datapath selects and a 2-bit operation class. A second decoder turns the operation class, and the function field when needed, into a 3-bit ALU operation. A load port fills either store while reset is held. Debug outputs show the current PC and the register write that commits at the next rising edge.

Top module: `sc_core`

## Requirements
- R1: While `rst` is high, the PC becomes 0 at the next rising edge and no register write is reported. After release, the first instruction executes from byte address 0.
- R2: Any instruction that does not take a branch sets the next PC to PC+4.
- R3: A load (opcode 100011) writes the data word at byte address rs + sign-extended imm[15:0] into register rt (bits 20-16). A negative offset reaches a lower address.
- R4: A store (opcode 101011) writes register rt to the data word at rs + sign-extended offset and reports no register write. A later load of that address returns the stored value.
- R5: Opcode 000000 selects a register-register operation that writes rd (bits 15-11). The function code in bits 5-0 picks the operation: 100000 add, 100010 subtract, 100100 and, 100101 or, 101010 set-less-than.
- R6: Set-less-than compares its operands as two's-complement numbers and writes 1 or 0.
- R7: Branch-if-equal (opcode 000100) sets the next PC to PC+4+(sign-extended offset << 2) when rs equals rt, otherwise to PC+4. Both forward and backward offsets work.
- R8: Register 0 always reads as zero. A write to register 0 is dropped, and the debug port shows no write for it.
- R9: An unrecognised opcode writes no register and no memory, and the PC advances by 4.
- R10: Loads and stores compute their address with the ALU add operation (010). Branches compare with the ALU subtract operation (110).
- R11: `dbg_rf_we`, `dbg_rf_addr` and `dbg_rf_data` describe, during the current cycle, the register write that commits at the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| ld_we | input | 1 | Load-port write strobe |
| ld_dmem | input | 1 | Load-port target: 0 instruction store, 1 data store |
| ld_addr | input | 6 | Load-port word index |
| ld_data | input | 32 | Load-port word |
| dbg_pc | output | 32 | Byte address of the instruction now executing |
| dbg_rf_we | output | 1 | A register write commits at the next edge |
| dbg_rf_addr | output | 5 | Destination register of that write |
| dbg_rf_data | output | 32 | Value of that write |

## Verification
The debug write outputs depend only on the current PC, so they are valid in the same cycle as the instruction that causes them. The PC moves to its next value one rising edge later. The bench samples each table step at the falling edge. It compares that step's PC and write report, then advances exactly one clock per step. A reset is seen one edge after `rst` rises, and that check is also made at a falling edge.

// File: rtl/sc_core_pkg.sv
package sc_core_pkg;

    localparam logic [5:0] OPC_RREG  = 6'b000000;
    localparam logic [5:0] OPC_LOAD  = 6'b100011;
    localparam logic [5:0] OPC_STORE = 6'b101011;
    localparam logic [5:0] OPC_BEQ   = 6'b000100;

    localparam logic [5:0] FN_ADD = 6'b100000;
    localparam logic [5:0] FN_SUB = 6'b100010;
    localparam logic [5:0] FN_AND = 6'b100100;
    localparam logic [5:0] FN_OR  = 6'b100101;
    localparam logic [5:0] FN_SLT = 6'b101010;

    typedef enum logic [2:0] {
        ALU_AND = 3'b000,
        ALU_OR  = 3'b001,
        ALU_ADD = 3'b010,
        ALU_SUB = 3'b110,
        ALU_SLT = 3'b111
    } alu_fn_e;

    typedef enum logic [1:0] {
        OPK_ADD   = 2'b00,
        OPK_SUB   = 2'b01,
        OPK_FIELD = 2'b10
    } op_kind_e;

    typedef enum logic [2:0] {
        CLS_RREG,
        CLS_LOAD,
        CLS_STORE,
        CLS_BRANCH,
        CLS_NONE
    } icls_e;

    typedef struct packed {
        logic     dst_rd;
        logic     b_imm;
        logic     wb_mem;
        logic     rf_wr;
        logic     mem_rd;
        logic     mem_wr;
        logic     branch;
        op_kind_e op_kind;
    } ctrl_t;

endpackage

// File: rtl/sc_main_dec.sv
module sc_main_dec
    import sc_core_pkg::*;
(
    input  logic [5:0] opcode,
    output icls_e      cls,
    output ctrl_t      ctl
);

    always_comb begin
        unique case (opcode)
            OPC_RREG:  cls = CLS_RREG;
            OPC_LOAD:  cls = CLS_LOAD;
            OPC_STORE: cls = CLS_STORE;
            OPC_BEQ:   cls = CLS_BRANCH;
            default:   cls = CLS_NONE;
        endcase
    end

    always_comb begin
        ctl = '0;
        unique case (cls)
            CLS_RREG: begin
                ctl.dst_rd  = 1'b1;
                ctl.rf_wr   = 1'b1;
                ctl.op_kind = OPK_FIELD;
            end
            CLS_LOAD: begin
                ctl.b_imm   = 1'b1;
                ctl.wb_mem  = 1'b1;
                ctl.rf_wr   = 1'b1;
                ctl.mem_rd  = 1'b1;
                ctl.op_kind = OPK_ADD;
            end
            CLS_STORE: begin
                ctl.b_imm   = 1'b1;
                ctl.mem_wr  = 1'b1;
                ctl.op_kind = OPK_ADD;
            end
            CLS_BRANCH: begin
                ctl.branch  = 1'b1;
                ctl.op_kind = OPK_SUB;
            end
            default: ctl = '0;
        endcase
    end

endmodule

// File: rtl/sc_alu_dec.sv
module sc_alu_dec
    import sc_core_pkg::*;
(
    input  op_kind_e   op_kind,
    input  logic [5:0] funct,
    output alu_fn_e    alu_fn
);

    always_comb begin
        unique case (op_kind)
            OPK_ADD: alu_fn = ALU_ADD;
            OPK_SUB: alu_fn = ALU_SUB;
            OPK_FIELD: begin
                unique case (funct)
                    FN_ADD:  alu_fn = ALU_ADD;
                    FN_SUB:  alu_fn = ALU_SUB;
                    FN_AND:  alu_fn = ALU_AND;
                    FN_OR:   alu_fn = ALU_OR;
                    FN_SLT:  alu_fn = ALU_SLT;
                    default: alu_fn = ALU_ADD;
                endcase
            end
            default: alu_fn = ALU_ADD;
        endcase
    end

endmodule

// File: rtl/sc_alu.sv
module sc_alu
    import sc_core_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    input  alu_fn_e         fn,
    output logic [XLEN-1:0] y,
    output logic            zero
);

    always_comb begin
        unique case (fn)
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_SLT: y = {{(XLEN-1){1'b0}}, ($signed(a) < $signed(b))};
            default: y = '0;
        endcase
    end

    assign zero = (y == '0);

endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
    parameter int XLEN  = 32,
    parameter int NREGS = 32,
    localparam int RAW  = $clog2(NREGS)
) (
    input  logic            clk,
    input  logic            we,
    input  logic [RAW-1:0]  wa,
    input  logic [XLEN-1:0] wd,
    input  logic [RAW-1:0]  ra1,
    input  logic [RAW-1:0]  ra2,
    output logic [XLEN-1:0] rd1,
    output logic [XLEN-1:0] rd2
);

    logic [XLEN-1:0] regs [NREGS];

    always_ff @(posedge clk) begin
        if (we && (wa != '0)) begin
            regs[wa] <= wd;
        end
    end

    assign rd1 = (ra1 == '0) ? '0 : regs[ra1];
    assign rd2 = (ra2 == '0) ? '0 : regs[ra2];

endmodule

// File: rtl/sc_core.sv
module sc_core
    import sc_core_pkg::*;
#(
    parameter int XLEN      = 32,
    parameter int MEM_WORDS = 64,
    parameter int NREGS     = 32,
    localparam int AW       = $clog2(MEM_WORDS),
    localparam int RAW      = $clog2(NREGS)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            ld_we,
    input  logic            ld_dmem,
    input  logic [AW-1:0]   ld_addr,
    input  logic [XLEN-1:0] ld_data,
    output logic [XLEN-1:0] dbg_pc,
    output logic            dbg_rf_we,
    output logic [RAW-1:0]  dbg_rf_addr,
    output logic [XLEN-1:0] dbg_rf_data
);

    logic [XLEN-1:0] imem [MEM_WORDS];
    logic [XLEN-1:0] dmem [MEM_WORDS];

    logic [XLEN-1:0] pc, pc_plus4, br_tgt, pc_nxt;
    logic [31:0]     instr;
    logic [XLEN-1:0] sext, rd1, rd2, alu_b, alu_y, rdata, wd;
    logic [RAW-1:0]  wa;
    logic [AW-1:0]   dm_idx;
    logic            alu_zero, take_br, rf_we;
    icls_e           cls;
    ctrl_t           ctl;
    alu_fn_e         alu_fn;
    logic            unused_bits;

    assign instr = imem[pc[AW+1:2]];
    assign sext  = {{(XLEN-16){instr[15]}}, instr[15:0]};

    sc_main_dec u_main_dec (
        .opcode (instr[31:26]),
        .cls    (cls),
        .ctl    (ctl)
    );

    sc_alu_dec u_alu_dec (
        .op_kind (ctl.op_kind),
        .funct   (instr[5:0]),
        .alu_fn  (alu_fn)
    );

    sc_regfile #(.XLEN(XLEN), .NREGS(NREGS)) u_rf (
        .clk (clk),
        .we  (rf_we),
        .wa  (wa),
        .wd  (wd),
        .ra1 (instr[25:21]),
        .ra2 (instr[20:16]),
        .rd1 (rd1),
        .rd2 (rd2)
    );

    assign alu_b = ctl.b_imm ? sext : rd2;

    sc_alu #(.XLEN(XLEN)) u_alu (
        .a    (rd1),
        .b    (alu_b),
        .fn   (alu_fn),
        .y    (alu_y),
        .zero (alu_zero)
    );

    assign wa     = ctl.dst_rd ? instr[15:11] : instr[20:16];
    assign dm_idx = alu_y[AW+1:2];
    assign rdata  = ctl.mem_rd ? dmem[dm_idx] : '0;
    assign wd     = ctl.wb_mem ? rdata : alu_y;
    assign rf_we  = ctl.rf_wr & ~rst;

    assign take_br  = ctl.branch & alu_zero;
    assign pc_plus4 = pc + XLEN'(4);
    assign br_tgt   = pc_plus4 + (sext << 2);
    assign pc_nxt   = take_br ? br_tgt : pc_plus4;

    always_ff @(posedge clk) begin
        if (rst) begin
            pc <= '0;
        end else begin
            pc <= pc_nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (ld_we && !ld_dmem) begin
            imem[ld_addr] <= ld_data;
        end
        if (ld_we && ld_dmem) begin
            dmem[ld_addr] <= ld_data;
        end else if (!rst && ctl.mem_wr) begin
            dmem[dm_idx] <= rd2;
        end
    end

    assign dbg_pc      = pc;
    assign dbg_rf_we   = rf_we && (wa != '0);
    assign dbg_rf_addr = wa;
    assign dbg_rf_data = wd;

    assign unused_bits = ^{instr[10:6], cls};

    // R1
    pc_reset_chk: assert property (@(posedge clk) rst |=> (pc == '0));

    // R2
    pc_step_chk: assert property (@(posedge clk) disable iff (rst)
        !take_br |=> (pc == $past(pc) + XLEN'(4)));

    // R8
    zero_reg_chk: assert property (@(posedge clk) disable iff (rst)
        (instr[25:21] == '0) |-> (rd1 == '0));

    // R10
    mem_add_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl.mem_rd || ctl.mem_wr) |-> (alu_fn == ALU_ADD));

    // R10
    br_sub_chk: assert property (@(posedge clk) disable iff (rst)
        ctl.branch |-> (alu_fn == ALU_SUB));

    // R4
    store_nowr_chk: assert property (@(posedge clk) disable iff (rst)
        ctl.mem_wr |-> !dbg_rf_we);

endmodule

// File: tb/sc_core_tb_top.sv
`timescale 1ns/1ps
module sc_core_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ld_we = 1'b0;
    logic        ld_dmem = 1'b0;
    logic [5:0]  ld_addr = '0;
    logic [31:0] ld_data = '0;
    logic [31:0] dbg_pc;
    logic        dbg_rf_we;
    logic [4:0]  dbg_rf_addr;
    logic [31:0] dbg_rf_data;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    sc_core dut_i (
        .clk         (clk),
        .rst         (rst),
        .ld_we       (ld_we),
        .ld_dmem     (ld_dmem),
        .ld_addr     (ld_addr),
        .ld_data     (ld_data),
        .dbg_pc      (dbg_pc),
        .dbg_rf_we   (dbg_rf_we),
        .dbg_rf_addr (dbg_rf_addr),
        .dbg_rf_data (dbg_rf_data)
    );

    localparam int NSTEP = 21;
    // {pc, write enable, write register, write data}
    localparam logic [69:0] EXP [NSTEP] = '{
        {32'd0,  1'b1, 5'd1,  32'd5},
        {32'd4,  1'b1, 5'd2,  32'd3},
        {32'd8,  1'b1, 5'd3,  32'hFFFFFFFE},
        {32'd12, 1'b1, 5'd4,  32'd8},
        {32'd16, 1'b1, 5'd5,  32'd2},
        {32'd20, 1'b1, 5'd6,  32'd1},
        {32'd24, 1'b1, 5'd7,  32'd7},
        {32'd28, 1'b1, 5'd8,  32'd1},
        {32'd32, 1'b1, 5'd9,  32'd0},
        {32'd36, 1'b0, 5'd0,  32'd0},
        {32'd40, 1'b1, 5'd10, 32'd5},
        {32'd44, 1'b0, 5'd0,  32'd0},
        {32'd48, 1'b1, 5'd11, 32'd8},
        {32'd52, 1'b1, 5'd12, 32'd3},
        {32'd56, 1'b0, 5'd0,  32'd0},
        {32'd60, 1'b0, 5'd0,  32'd0},
        {32'd72, 1'b0, 5'd0,  32'd0},
        {32'd76, 1'b1, 5'd14, 32'd8},
        {32'd80, 1'b0, 5'd0,  32'd0},
        {32'd88, 1'b0, 5'd0,  32'd0},
        {32'd88, 1'b0, 5'd0,  32'd0}
    };

    function automatic string step_req(int i);
        case (i)
            0:       return "R11";
            1, 2:    return "R3";
            3, 4, 5, 6: return "R5";
            7, 8:    return "R6";
            9, 10:   return "R8";
            11, 12:  return "R4";
            13:      return "R3";
            15:      return "R10";
            16:      return "R9";
            17:      return "R2";
            default: return "R7";
        endcase
    endfunction

    function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
        return {6'b000000, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
    endfunction

    function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, logic [15:0] imm);
        return {op, 5'(rs), 5'(rt), imm};
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic load_word(logic sel, int idx, logic [31:0] w);
        @(negedge clk);
        ld_we   = 1'b1;
        ld_dmem = sel;
        ld_addr = 6'(idx);
        ld_data = w;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog act=running exp=finished");
        finish_run();
    end

    initial begin
        logic [31:0] prog [23];
        prog[0]  = enc_i(6'b100011, 0, 1, 16'd0);
        prog[1]  = enc_i(6'b100011, 0, 2, 16'd4);
        prog[2]  = enc_i(6'b100011, 0, 3, 16'd8);
        prog[3]  = enc_r(1, 2, 4, 6'b100000);
        prog[4]  = enc_r(1, 2, 5, 6'b100010);
        prog[5]  = enc_r(1, 2, 6, 6'b100100);
        prog[6]  = enc_r(1, 2, 7, 6'b100101);
        prog[7]  = enc_r(3, 1, 8, 6'b101010);
        prog[8]  = enc_r(1, 3, 9, 6'b101010);
        prog[9]  = enc_r(1, 2, 0, 6'b100000);
        prog[10] = enc_r(0, 1, 10, 6'b100000);
        prog[11] = enc_i(6'b101011, 0, 4, 16'd12);
        prog[12] = enc_i(6'b100011, 0, 11, 16'd12);
        prog[13] = enc_i(6'b100011, 4, 12, 16'hFFFC);
        prog[14] = enc_i(6'b000100, 1, 2, 16'd5);
        prog[15] = enc_i(6'b000100, 1, 10, 16'd2);
        prog[16] = enc_r(1, 1, 13, 6'b100000);
        prog[17] = enc_r(1, 1, 13, 6'b100000);
        prog[18] = 32'hFC000000;
        prog[19] = enc_r(1, 2, 14, 6'b100000);
        prog[20] = enc_i(6'b000100, 14, 4, 16'd1);
        prog[21] = enc_r(1, 1, 13, 6'b100000);
        prog[22] = enc_i(6'b000100, 0, 0, 16'hFFFF);

        // R1: reset state
        @(negedge clk);
        @(negedge clk);
        chk("R1", dbg_pc, 32'd0);
        chk("R1", {31'd0, dbg_rf_we}, 32'd0);

        for (int i = 0; i < 23; i++) load_word(1'b0, i, prog[i]);
        load_word(1'b1, 0, 32'd5);
        load_word(1'b1, 1, 32'd3);
        load_word(1'b1, 2, 32'hFFFFFFFE);
        load_word(1'b1, 3, 32'd0);
        @(negedge clk);
        ld_we = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        #1;

        for (int i = 0; i < NSTEP; i++) begin
            logic [69:0] e;
            e = EXP[i];
            chk(step_req(i), dbg_pc, e[69:38]);
            chk(step_req(i), {31'd0, dbg_rf_we}, {31'd0, e[37]});
            if (e[37]) begin
                chk(step_req(i), {27'd0, dbg_rf_addr}, {27'd0, e[36:32]});
                chk(step_req(i), dbg_rf_data, e[31:0]);
            end
            @(negedge clk);
            #1;
        end

        // R1: reset in mid-run returns the PC to 0
        rst = 1'b1;
        @(negedge clk);
        #1;
        chk("R1", dbg_pc, 32'd0);
        chk("R1", {31'd0, dbg_rf_we}, 32'd0);
        rst = 1'b0;
        #1;
        chk("R1", dbg_pc, 32'd0);
        chk("R3", {27'd0, dbg_rf_addr}, 32'd1);
        chk("R3", dbg_rf_data, 32'd5);
        @(negedge clk);
        #1;
        chk("R2", dbg_pc, 32'd4);

        finish_run();
    end

endmodule